// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Vector Unit

This block gathers the event pulses of an I2C master controller (from its bit engine and its FIFO logic) into a sticky 16-bit status register. A 16-bit enable register selects which of those flags may raise the single level interrupt line. Software reads and acknowledges the flags through a small register port. Writing a 1 to a flag clears it.

An older software model reads an encoded vector register instead. That read returns a small code for the most urgent pending bus event and clears that one flag in the same access. The bus-busy flag is not latched. It mirrors a live input and can never cause an interrupt.

Register port map (2-bit address): 0 = status, 1 = enable, 2 = vector, 3 = unused (reads zero). Reads are combinational: `reg_rdata` reflects `reg_addr` in the same cycle. Writes and read side effects take place at the next rising clock edge.

Top module: `i2c_irq_unit`

## Requirements
- R1: After reset, status and enable read zero, the vector reads 0 and `irq_o` is low.
- R2: A one-cycle pulse on `evt_i[n]` sets status bit n at the next clock edge, and the bit stays set until cleared. This applies to the latched flags: bit 0 arbitration lost, bit 1 no-ack, bit 2 access ready, bit 3 receive ready, bit 4 transmit ready, bit 8 address zero, bit 9 addressed as target, bit 10 transmit underflow, bit 11 receive overrun, bit 13 receive drain and bit 14 transmit drain.
- R3: A write to address 0 clears every status bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R4: When an event pulse and a clear (by write or by vector read) hit the same bit in the same cycle, the bit ends up set.
- R5: The enable register (address 1) stores write-data bits 0 to 4, 13 and 14. All of its other bits read zero.
- R6: `irq_o` is high in every cycle in which status AND enable is nonzero, and low otherwise.
- R7: The vector (address 2) reads 0 when status bits 0 to 4 are all clear. Otherwise it reads the code n+1 for the lowest set bit n among bits 0 to 4: 1 arbitration lost, 2 no-ack, 3 access ready, 4 receive ready, 5 transmit ready. Enable has no effect on the vector.
- R8: A read of the vector clears only the status bit it reports. A later vector read then reports the next pending source.
- R9: Status bit 12 reads the live value of `bus_busy_i`. `evt_i[12]` has no effect, and bit 12 never drives `irq_o`.
- R10: Status bits 5 to 7 and bit 15 always read zero, and events or writes on those positions are ignored. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (needed for vector clear) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| evt_i | input | 16 | One-cycle event pulses at status positions |
| bus_busy_i | input | 1 | Live bus-busy level |
| irq_o | output | 1 | Level interrupt |

## Verification
Sparse random event pulses are mixed with random write-1 clears, enable writes and vector reads, and all are compared with a bench model. This shows whether set, clear and masking agree bit by bit. Directed sequences place several vector sources pending at once to test the priority order and the one-flag-per-read clearing. A pulse on the very bit being cleared tests set-over-clear. Toggling bus busy with every enable bit on, and firing events at reserved positions, shows that bit 12 only mirrors its input and that the unused bits stay inert.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int STAT_W   = 16;
    localparam int SEL_W    = 2;
    localparam int VEC_SRCS = 5;
    localparam int VEC_W    = $clog2(VEC_SRCS + 1);
    localparam int BUSY_POS = 12;

    // latched flags: bits 0..4, 8..11, 13, 14
    localparam logic [STAT_W-1:0] LATCH_MASK  = 16'h6F1F;
    // maskable interrupt sources: bits 0..4, 13, 14
    localparam logic [STAT_W-1:0] ENABLE_MASK = 16'h601F;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_VECTOR = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/i2c_irq_status.sv
module i2c_irq_status #(
    parameter int                W    = 16,
    parameter logic [W-1:0]      MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_cell
            logic flag_q;
            always_ff @(posedge clk) begin
                if (!rst_n)        flag_q <= 1'b0;
                else if (set_i[i]) flag_q <= 1'b1;
                else if (clr_i[i]) flag_q <= 1'b0;
            end
            assign q_o[i] = flag_q;

            assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[i] |=> q_o[i]);
            assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[i] && !set_i[i]) |=> !q_o[i]);
            assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr_i[i] && !set_i[i]) |=> $stable(q_o[i]));
        end else begin : g_tie
            assign q_o[i] = 1'b0;
        end
    end

endmodule

// File: rtl/i2c_irq_vector.sv
module i2c_irq_vector #(
    parameter int SRCS = 5,
    parameter int VW   = $clog2(SRCS + 1)
) (
    input  logic [SRCS-1:0] pend_i,
    output logic [VW-1:0]   code_o,
    output logic [SRCS-1:0] pick_o
);

    always_comb begin
        code_o = '0;
        pick_o = '0;
        for (int n = SRCS - 1; n >= 0; n--) begin
            if (pend_i[n]) begin
                code_o = VW'(n + 1);
                pick_o = '0;
                pick_o[n] = 1'b1;
            end
        end
    end

    always_comb begin
        if (!$isunknown(pend_i)) begin
            assert_pick_onehot_R7: assert ($onehot0(pick_o));
            assert_pick_pending_R7: assert ((pick_o & ~pend_i) == '0);
            assert_code_none_R7: assert ((code_o == '0) == (pend_i == '0));
        end
    end

endmodule

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit
    import i2c_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    input  logic [STAT_W-1:0] evt_i,
    input  logic              bus_busy_i,
    output logic              irq_o
);

    reg_sel_e           sel;
    logic [STAT_W-1:0]  status_q;
    logic [STAT_W-1:0]  enable_q;
    logic [STAT_W-1:0]  set_bits;
    logic [STAT_W-1:0]  clr_bits;
    logic [STAT_W-1:0]  status_view;
    logic [VEC_W-1:0]   vec_code;
    logic [VEC_SRCS-1:0] vec_pick;
    logic               vec_take;

    assign sel      = reg_sel_e'(reg_addr);
    assign vec_take = reg_rd && (sel == SEL_VECTOR);
    assign set_bits = evt_i & LATCH_MASK;

    always_comb begin
        clr_bits = '0;
        if (reg_wr && sel == SEL_STATUS)
            clr_bits = reg_wdata & LATCH_MASK;
        if (vec_take)
            clr_bits[VEC_SRCS-1:0] = clr_bits[VEC_SRCS-1:0] | vec_pick;
    end

    i2c_irq_status #(.W(STAT_W), .MASK(LATCH_MASK)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_bits),
        .clr_i (clr_bits),
        .q_o   (status_q)
    );

    i2c_irq_vector #(.SRCS(VEC_SRCS), .VW(VEC_W)) u_vector (
        .pend_i (status_q[VEC_SRCS-1:0]),
        .code_o (vec_code),
        .pick_o (vec_pick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_q <= '0;
        else if (reg_wr && sel == SEL_ENABLE)
            enable_q <= reg_wdata & ENABLE_MASK;
    end

    always_comb begin
        status_view = status_q;
        status_view[BUSY_POS] = bus_busy_i;
    end

    always_comb begin
        unique case (sel)
            SEL_STATUS: reg_rdata = status_view;
            SEL_ENABLE: reg_rdata = enable_q;
            SEL_VECTOR: reg_rdata = STAT_W'(vec_code);
            default:    reg_rdata = '0;
        endcase
    end

    assign irq_o = |(status_q & enable_q);

    assert_mask_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel == SEL_ENABLE && reg_wdata == '0) |=> !irq_o);
    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_STATUS) |-> (reg_rdata[7:5] == 3'b0 && !reg_rdata[15]));
    assert_busy_no_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & enable_q & ~(STAT_W'(1) << BUSY_POS)) == '0) |-> !irq_o);

    for (genvar s = 0; s < VEC_SRCS; s++) begin : g_vchk
        assert_vec_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (vec_take && vec_pick[s] && !set_bits[s] && !reg_wr) |=> !status_q[s]);
    end

endmodule

// File: tb/tb_i2c_irq_unit.sv
module tb_i2c_irq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] evt_i = '0;
    logic        bus_busy_i = 1'b0;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    logic [15:0] m_stat = '0;
    logic [15:0] m_en = '0;

    localparam logic [15:0] LMASK = 16'h6F1F;
    localparam logic [15:0] EMASK = 16'h601F;

    always #10 clk = ~clk;

    i2c_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_i(evt_i), .bus_busy_i(bus_busy_i), .irq_o(irq_o)
    );

    function automatic logic [15:0] f_vec(input logic [15:0] st);
        for (int n = 0; n < 5; n++)
            if (st[n]) return 16'(n + 1);
        return 16'd0;
    endfunction

    function automatic logic [15:0] f_read(input logic [1:0] a, input logic bb);
        case (a)
            2'd0: return (m_stat & LMASK) | (16'(bb) << 12);
            2'd1: return m_en;
            2'd2: return f_vec(m_stat);
            default: return 16'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic step(input logic [1:0] a, input logic w, input logic r,
                        input logic [15:0] wd, input logic [15:0] ev,
                        input logic bb, input string tag);
        logic [15:0] clr;
        logic [15:0] vcode;
        @(negedge clk);
        reg_addr = a; reg_wr = w; reg_rd = r; reg_wdata = wd;
        evt_i = ev; bus_busy_i = bb;
        #2;
        if (r) check(tag, reg_rdata, f_read(a, bb));
        check("R6 irq", 16'(irq_o), 16'(|(m_stat & m_en)));
        clr = (w && a == 2'd0) ? (wd & LMASK) : 16'd0;
        vcode = f_vec(m_stat);
        if (r && a == 2'd2 && vcode != 0) clr[vcode - 1] = 1'b1;
        @(posedge clk);
        m_stat = (m_stat & ~clr) | (ev & LMASK);
        if (w && a == 2'd1) m_en = wd & EMASK;
        #1;
        reg_wr = 1'b0; reg_rd = 1'b0; evt_i = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        step(2'd0, 0, 1, 0, 0, 0, "R1 status");
        step(2'd1, 0, 1, 0, 0, 0, "R1 enable");
        step(2'd2, 0, 1, 0, 0, 0, "R1 vector");
        // R2: every latched position
        step(2'd0, 0, 0, 0, 16'hFFFF, 0, "R2");
        step(2'd0, 0, 1, 0, 0, 0, "R2 all latched, R10 reserved zero");
        step(2'd0, 0, 1, 0, 0, 0, "R2 sticky");
        // R3: write 0 keeps, write 1 clears
        step(2'd0, 1, 0, 16'h0000, 0, 0, "R3");
        step(2'd0, 0, 1, 0, 0, 0, "R3 write0 keeps");
        step(2'd0, 1, 0, 16'h0F0F, 0, 0, "R3");
        step(2'd0, 0, 1, 0, 0, 0, "R3 partial clear");
        // R4: set wins over write clear
        step(2'd0, 1, 0, 16'hFFFF, 16'h0002, 0, "R4");
        step(2'd0, 0, 1, 0, 0, 0, "R4 set wins write");
        // R7/R8: priority order and per-read clearing
        step(2'd0, 0, 0, 0, 16'h001C, 0, "R7");
        step(2'd2, 0, 1, 0, 0, 0, "R7 code2 first");
        step(2'd2, 0, 1, 0, 0, 0, "R8 code3 next");
        step(2'd0, 0, 1, 0, 0, 0, "R8 only reported cleared");
        step(2'd2, 0, 1, 0, 16'h0008, 0, "R4 R8 vector clear vs set");
        step(2'd2, 0, 1, 0, 0, 0, "R8 code4 kept");
        // R5 / R6
        step(2'd1, 1, 0, 16'hFFFF, 0, 0, "R5");
        step(2'd1, 0, 1, 0, 0, 0, "R5 writable bits");
        step(2'd1, 0, 0, 0, 0, 0, "R6");
        step(2'd0, 1, 0, 16'hFFFF, 0, 0, "R6");
        step(2'd0, 0, 0, 0, 0, 0, "R6 clear drops irq");
        // R9: busy mirror, no irq, event at 12 ignored
        step(2'd0, 0, 1, 0, 16'h1000, 1, "R9 busy live");
        step(2'd0, 0, 1, 0, 0, 0, "R9 not latched");
        step(2'd0, 0, 1, 0, 0, 1, "R9 busy no irq");
        // R10: reserved positions and address 3
        step(2'd0, 1, 0, 16'h80E0, 16'h80E0, 0, "R10");
        step(2'd0, 0, 1, 0, 0, 0, "R10 reserved ignored");
        step(2'd3, 1, 1, 16'hFFFF, 0, 0, "R10 addr3 zero");
        // random mix
        for (int k = 0; k < 3000; k++) begin
            logic [1:0]  a;
            logic [15:0] ev;
            string tg;
            a  = 2'($urandom_range(0, 3));
            ev = 16'($urandom & $urandom & $urandom);
            case (a)
                2'd0: tg = "R2 R3 random status";
                2'd1: tg = "R5 random enable";
                2'd2: tg = "R7 R8 random vector";
                default: tg = "R10 random none";
            endcase
            step(a, 1'($urandom_range(0, 3) == 0), 1'($urandom),
                 16'($urandom), ev, 1'($urandom), tg);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule